// File: doc/BRIEF.md
# Sync-Clocked EDID Byte Streamer

This block sends display identification bytes over a single transmit-only data line. The vertical sync input serves as the bit clock. A CPU loads bytes into an eight-entry queue through a write strobe. The serializer takes one byte at a time and shifts it out most significant bit first. After the eight data bits it sends one separator bit that is always high, so each byte occupies nine sync periods. When the queue runs dry, the line rests high.

Two flags tell software how full the queue is. A low-water flag rises when fewer than a selectable number of bytes (two to five) are waiting, and a maskable interrupt follows that flag. A full flag reports eight waiting bytes. An optional auto-fill path saves software work. When it is on, each CPU read of the memory-buffer register also pushes the value that register presents into the queue.

Top module: `edid_stream_tx`

## Requirements
- R1: While reset is held and on the first cycle after it, the data line is high, the low-water flag is 1, the full flag is 0 and the interrupt is 0.
- R2: A byte is sent over nine rising edges of the synchronized sync input. Edges 1 to 8 carry data bits 7 down to 0, and edge 9 carries a 1.
- R3: The next queued byte starts on the edge right after a separator bit. With nothing queued, every further rising edge leaves the line at 1.
- R4: Bytes leave in the order they entered the queue.
- R5: The full flag is 1 exactly when 8 bytes are waiting. A write made while the queue is full is dropped, and that byte is never sent.
- R6: The low-water flag is 1 exactly when the number of waiting bytes is below a mark N. The 2-bit select field sets N: 00 gives 2, 01 gives 3, 10 gives 4 and 11 gives 5.
- R7: The interrupt output equals the low-water flag ANDed with the interrupt enable input.
- R8: When the auto-fill enable is 1, a buffer-read strobe pushes the buffer data into the queue. When the enable is 0, the strobe pushes nothing.
- R9: If a CPU write and an auto-fill push happen in the same cycle, only the written byte is queued.
- R10: A falling edge of the sync input, or a steady sync level, leaves the data line unchanged.
- R11: A byte leaves the queue at the rising edge that sends its first bit, so the waiting count drops by one at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| vsync_in | input | 1 | Asynchronous vertical sync, used as the bit clock |
| wr_en | input | 1 | CPU write strobe into the queue |
| wr_data | input | 8 | CPU write byte |
| buf_rd_en | input | 1 | CPU read strobe of the memory-buffer register |
| buf_data | input | 8 | Value the memory-buffer register presents |
| autofill_en | input | 1 | Lets buffer reads push into the queue |
| low_sel | input | 2 | Low-water mark select (N = value + 2) |
| low_irq_en | input | 1 | Interrupt mask for the low-water flag |
| sda_out | output | 1 | Serial data line |
| fifo_low | output | 1 | Low-water flag |
| fifo_full | output | 1 | Full flag |
| low_irq | output | 1 | Masked low-water interrupt |

## Verification
The bench builds the block with its default parameters: 8-bit bytes, an eight-entry queue and a two-stage synchronizer. That queue is small enough to step the fill level through every value from 0 to 8 under all four low-water selects, so every flag and interrupt outcome is compared with arithmetic done in the bench. Each fill is then drained one bit at a time, which covers ordering, back-to-back framing, the dropped ninth write and the idle line. Short directed runs cover auto-fill on, auto-fill off and a write colliding with an auto-fill push.

// File: rtl/edid_stream_pkg.sv
package edid_stream_pkg;

  typedef enum logic [1:0] {
    SER_IDLE,
    SER_DATA,
    SER_STOP
  } ser_state_t;

  // Low-water mark: select value plus two.
  function automatic int unsigned low_mark(input logic [1:0] sel);
    return 32'(sel) + 32'd2;
  endfunction

endpackage

// File: rtl/vsync_edge_det.sv
module vsync_edge_det #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic async_in,
  output logic rise
);

  logic [STAGES-1:0] sync_q;
  logic              last_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) sync_q <= '0;
        else     sync_q <= async_in;
      end
    end else begin : g_chain
      always_ff @(posedge clk) begin
        if (rst) sync_q <= '0;
        else     sync_q <= {sync_q[STAGES-2:0], async_in};
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) last_q <= 1'b0;
    else     last_q <= sync_q[STAGES-1];
  end

  assign rise = sync_q[STAGES-1] & ~last_q;

endmodule

// File: rtl/edid_byte_fifo.sv
module edid_byte_fifo
  import edid_stream_pkg::*;
#(
  parameter int W     = 8,
  parameter int DEPTH = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push,
  input  logic [W-1:0] push_data,
  input  logic         pop,
  input  logic [1:0]   low_sel,
  input  logic         irq_en,
  output logic [W-1:0] rd_data,
  output logic         empty,
  output logic         full_o,
  output logic         low_o,
  output logic         irq_o
);

  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(DEPTH);
  localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(DEPTH - 1);

  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic [CNT_W-1:0] count, count_n;
  logic             do_push, do_pop, low_n;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == PTR_LAST) ? '0 : p + 1'b1;
  endfunction

  assign empty   = (count == '0);
  assign do_push = push & (count != CNT_FULL);
  assign do_pop  = pop & ~empty;

  always_comb begin
    count_n = count;
    if (do_push && !do_pop)      count_n = count + 1'b1;
    else if (do_pop && !do_push) count_n = count - 1'b1;
  end

  assign low_n = (count_n < CNT_W'(low_mark(low_sel)));

  // Storage without reset so it maps onto RAM primitives.
  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= push_data;
  end

  assign rd_data = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
      full_o <= 1'b0;
      low_o  <= 1'b1;
      irq_o  <= 1'b0;
    end else begin
      if (do_push) wr_ptr <= bump(wr_ptr);
      if (do_pop)  rd_ptr <= bump(rd_ptr);
      count  <= count_n;
      full_o <= (count_n == CNT_FULL);
      low_o  <= low_n;
      irq_o  <= low_n & irq_en;
    end
  end

endmodule

// File: rtl/edid_packet_ser.sv
module edid_packet_ser
  import edid_stream_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick,
  input  logic         empty,
  input  logic [W-1:0] rd_data,
  output logic         pop,
  output logic         sda
);

  localparam int BC_W = (W > 1) ? $clog2(W) : 1;
  localparam logic [BC_W-1:0] BC_LAST = BC_W'(W - 1);

  ser_state_t      state;
  logic [BC_W-1:0] bit_cnt;
  logic [W-1:0]    shreg;

  assign pop = tick & ~empty & (state != SER_DATA);

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= SER_IDLE;
      bit_cnt <= '0;
      shreg   <= '0;
      sda     <= 1'b1;
    end else if (tick) begin
      if (state == SER_DATA) begin
        if (bit_cnt == BC_LAST) begin
          state <= SER_STOP;
          sda   <= 1'b1;
        end else begin
          bit_cnt <= bit_cnt + 1'b1;
          sda     <= shreg[W-1];
          shreg   <= shreg << 1;
        end
      end else if (!empty) begin
        state   <= SER_DATA;
        bit_cnt <= '0;
        sda     <= rd_data[W-1];
        shreg   <= rd_data << 1;
      end else begin
        state <= SER_IDLE;
        sda   <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/edid_stream_tx.sv
module edid_stream_tx
  import edid_stream_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int FIFO_DEPTH  = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              vsync_in,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              buf_rd_en,
  input  logic [DATA_W-1:0] buf_data,
  input  logic              autofill_en,
  input  logic [1:0]        low_sel,
  input  logic              low_irq_en,
  output logic              sda_out,
  output logic              fifo_low,
  output logic              fifo_full,
  output logic              low_irq
);

  logic              vs_rise;
  logic              push, pop, empty;
  logic [DATA_W-1:0] push_data, head;

  // Direct writes win over the auto-fill path.
  assign push      = wr_en | (buf_rd_en & autofill_en);
  assign push_data = wr_en ? wr_data : buf_data;

  vsync_edge_det #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst      (rst),
    .async_in (vsync_in),
    .rise     (vs_rise)
  );

  edid_byte_fifo #(.W(DATA_W), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk       (clk),
    .rst       (rst),
    .push      (push),
    .push_data (push_data),
    .pop       (pop),
    .low_sel   (low_sel),
    .irq_en    (low_irq_en),
    .rd_data   (head),
    .empty     (empty),
    .full_o    (fifo_full),
    .low_o     (fifo_low),
    .irq_o     (low_irq)
  );

  edid_packet_ser #(.W(DATA_W)) u_ser (
    .clk     (clk),
    .rst     (rst),
    .tick    (vs_rise),
    .empty   (empty),
    .rd_data (head),
    .pop     (pop),
    .sda     (sda_out)
  );

endmodule

// File: rtl/edid_stream_chk.sv
module edid_stream_chk (
  input logic clk,
  input logic rst,
  input logic tick,
  input logic sda_out,
  input logic fifo_low,
  input logic fifo_full,
  input logic low_irq,
  input logic low_irq_en
);

  logic seen_run;
  always_ff @(posedge clk) begin
    if (rst) seen_run <= 1'b0;
    else     seen_run <= 1'b1;
  end

  assert_reset_state_R1: assert property (@(posedge clk) disable iff (rst)
    (!seen_run) |-> (sda_out && fifo_low && !fifo_full && !low_irq));

  assert_irq_gated_R7: assert property (@(posedge clk) disable iff (rst)
    (seen_run && low_irq) |-> (fifo_low && $past(low_irq_en)));

  assert_full_not_low_R6: assert property (@(posedge clk) disable iff (rst)
    fifo_full |-> !fifo_low);

  assert_full_holds_R5: assert property (@(posedge clk) disable iff (rst)
    (fifo_full && !tick) |=> fifo_full);

  assert_line_quiet_R10: assert property (@(posedge clk) disable iff (rst)
    (!tick) |=> $stable(sda_out));

endmodule

bind edid_stream_tx edid_stream_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .tick       (vs_rise),
  .sda_out    (sda_out),
  .fifo_low   (fifo_low),
  .fifo_full  (fifo_full),
  .low_irq    (low_irq),
  .low_irq_en (low_irq_en)
);

// File: tb/sim_edid_stream_tx.sv
`timescale 1ns/1ps
module sim_edid_stream_tx;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       vsync_in = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic       buf_rd_en = 1'b0;
  logic [7:0] buf_data = '0;
  logic       autofill_en = 1'b0;
  logic [1:0] low_sel = 2'b00;
  logic       low_irq_en = 1'b0;
  logic       sda_out, fifo_low, fifo_full, low_irq;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  edid_stream_tx u0 (
    .clk(clk), .rst(rst), .vsync_in(vsync_in),
    .wr_en(wr_en), .wr_data(wr_data),
    .buf_rd_en(buf_rd_en), .buf_data(buf_data), .autofill_en(autofill_en),
    .low_sel(low_sel), .low_irq_en(low_irq_en),
    .sda_out(sda_out), .fifo_low(fifo_low), .fifo_full(fifo_full), .low_irq(low_irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
  endtask

  task automatic push_byte(input logic [7:0] d);
    wr_en = 1'b1;
    wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    @(negedge clk);
  endtask

  task automatic buf_read(input logic en, input logic [7:0] d);
    autofill_en = en;
    buf_data = d;
    buf_rd_en = 1'b1;
    @(negedge clk);
    buf_rd_en = 1'b0;
    @(negedge clk);
  endtask

  // One sync period; returns the line level after the rising edge.
  task automatic vs_edge(output logic b);
    vsync_in = 1'b1;
    repeat (4) @(negedge clk);
    b = sda_out;
    vsync_in = 1'b0;
    repeat (4) @(negedge clk);
    chk("R10 line after falling edge", 32'(sda_out), 32'(b));
  endtask

  task automatic recv_byte(input logic [7:0] exp, input string tag, input bit full_drop);
    logic b;
    for (int i = 0; i < 8; i++) begin
      vs_edge(b);
      chk({tag, " R2 data bit"}, 32'(b), 32'(exp[7-i]));
      if (i == 0 && full_drop) chk("R11 full clears at first bit", 32'(fifo_full), 32'd0);
    end
    vs_edge(b);
    chk({tag, " R2 separator"}, 32'(b), 32'd1);
  endtask

  function automatic logic [7:0] pat(input int s, input int i);
    return 8'((s * 8 + i) * 29 + 53);
  endfunction

  initial begin
    do_reset();
    chk("R1 line high", 32'(sda_out), 32'd1);
    chk("R1 low flag", 32'(fifo_low), 32'd1);
    chk("R1 full flag", 32'(fifo_full), 32'd0);
    chk("R1 irq", 32'(low_irq), 32'd0);

    for (int s = 0; s < 4; s++) begin
      low_sel = 2'(s);
      do_reset();
      for (int occ = 0; occ <= 8; occ++) begin
        low_irq_en = occ[0];
        @(negedge clk);
        chk("R6 low flag vs mark", 32'(fifo_low), 32'(occ < s + 2));
        chk("R5 full flag", 32'(fifo_full), 32'(occ == 8));
        chk("R7 irq masking", 32'(low_irq), 32'((occ < s + 2) && occ[0]));
        if (occ < 8) push_byte(pat(s, occ));
      end
      push_byte(8'h0F);
      chk("R5 full after dropped write", 32'(fifo_full), 32'd1);
      for (int i = 0; i < 8; i++) recv_byte(pat(s, i), "R4 order", i == 0);
      recv_byte(8'hFF, "R3 idle after drain", 1'b0);
      chk("R3 low flag when drained", 32'(fifo_low), 32'd1);
    end

    low_sel = 2'b00;
    low_irq_en = 1'b0;
    do_reset();
    buf_read(1'b1, 8'h3C);
    chk("R8 auto-fill pushes", 32'(fifo_low), 32'd1);
    buf_read(1'b0, 8'h99);
    chk("R8 disabled read pushes nothing", 32'(fifo_low), 32'd1);
    buf_read(1'b1, 8'hE7);
    chk("R8 second auto-fill push", 32'(fifo_low), 32'd0);
    recv_byte(8'h3C, "R8 first", 1'b0);
    recv_byte(8'hE7, "R8 second", 1'b0);
    recv_byte(8'hFF, "R8 nothing more R3", 1'b0);

    do_reset();
    autofill_en = 1'b1;
    buf_data = 8'hC3;
    buf_rd_en = 1'b1;
    wr_en = 1'b1;
    wr_data = 8'h5A;
    @(negedge clk);
    wr_en = 1'b0;
    buf_rd_en = 1'b0;
    @(negedge clk);
    chk("R9 one byte queued", 32'(fifo_low), 32'd1);
    recv_byte(8'h5A, "R9 write wins", 1'b0);
    recv_byte(8'hFF, "R9 fill dropped", 1'b0);

    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule